// File: doc/BRIEF.md
# Greedy Sparse-Support Selection Controller

This block steers the selection loop of a greedy sparse-support search. Each iteration is one matching pass. The datapath streams one correlation magnitude per dictionary column, in column order. The controller keeps the largest magnitude seen so far and the column that produced it. Columns that are already in the support take no part in the comparison. When the last column arrives, the winning column is appended to the support list.

The controller then waits for the datapath to report the energy that this iteration recovered, and decides whether to stop. It stops when the energy falls below a threshold, or when the support has reached its size limit. A fixed-count mode skips the energy test, so the loop always returns exactly the limit number of indices.

The threshold, the size limit and the mode are captured when the start pulse arrives. After a stop, the block holds the list, the count and the stop reason until the next start. Projection and residual arithmetic are done elsewhere.

Top module: `sparse_pick_ctrl`

## Requirements
- R1: After reset, `sup_count`, `done`, `stop_by_energy` and every slot of `sup_list` are zero. A `start` pulse returns them all to zero in the next cycle and begins a matching pass.
- R2: A matching pass consists of NCOL accepted `corr_valid` beats. Beat k (counting from 0) carries column k. In the cycle after the beat for column NCOL-1, the winning column sits in slot `sup_count`-1 and `sup_count` has grown by one. Slot i occupies bits [i*IDX_W +: IDX_W] of `sup_list`.
- R3: The winner is the column with the largest `corr_mag` among the columns that are not excluded. On equal magnitudes, the lower column index wins.
- R4: A column already held in the support is ignored in later passes of the same run, even when it carries the largest magnitude, so no index is chosen twice.
- R5: After a pass, the first `energy_valid` beat is compared with the threshold. The loop continues with a new pass, with `done` staying 0, when both of these hold: `energy_val` >= threshold (or fixed mode is on), and `sup_count` is below the limit.
- R6: If fixed mode is off and `energy_val` < threshold, the last appended index is removed. Its slot then reads zero, `sup_count` drops by one, and in the next cycle `done`=1 and `stop_by_energy`=1.
- R7: If the energy test passes and `sup_count` equals the limit, then in the next cycle `done`=1, `stop_by_energy`=0 and `sup_count` equals the limit.
- R8: With `cfg_fixed`=1, the energy value has no effect. The run ends after exactly `limit` passes with `stop_by_energy`=0.
- R9: When the energy of the pass that reaches the limit is below the threshold, the energy stop wins. The run ends with `sup_count` = limit-1 and `stop_by_energy`=1.
- R10: A `cfg_limit` of 0 is treated as 1. A value above MAX_SUPPORT is treated as MAX_SUPPORT.
- R11: `corr_valid` is ignored outside a matching pass, and `energy_valid` is ignored outside the energy wait. After `done`, neither changes `sup_count`, `sup_list` or `done`.
- R12: Slots at index `sup_count` and above always read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Pulse: clear the support, capture the configuration, begin a run |
| cfg_limit | input | CNT_W (4) | Maximum support size, clamped to 1..MAX_SUPPORT |
| cfg_thresh | input | EN_W (24) | Energy threshold |
| cfg_fixed | input | 1 | 1: ignore the energy test and return exactly the limit number of indices |
| corr_valid | input | 1 | Correlation beat valid |
| corr_mag | input | MAG_W (18) | Unsigned correlation magnitude of the current column |
| energy_valid | input | 1 | Iteration energy valid |
| energy_val | input | EN_W (24) | Unsigned energy contribution of the iteration |
| sup_list | output | MAX_SUPPORT*IDX_W (56) | Support indices, slot 0 in the low bits |
| sup_count | output | CNT_W (4) | Number of valid slots |
| done | output | 1 | Run finished |
| stop_by_energy | output | 1 | 1: the run ended on the energy test; 0: it ended on the size limit |

## Verification
The size-limit stop and the energy stop can both become true on the same energy beat. This happens when the pass that fills the support to its limit also reports energy below the threshold. The bench provokes it with a limit of 2 and a low second energy. It expects the energy rule to win: one index is removed, the count is 1, and the stop reason is energy. The bench also places a tie on the column that a pass would otherwise choose, and a maximal magnitude on an excluded column, within the same pass sequence. In each case the chosen index is compared with the bench's own argmax.

// File: rtl/sps_pkg.sv
package sps_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_MATCH,
    ST_WAIT_E,
    ST_DONE
  } sps_state_e;

  // Candidate takes the lead only on a strictly larger magnitude (lower index wins ties).
  function automatic logic beats_lead(input logic have_lead,
                                      input logic [31:0] cand,
                                      input logic [31:0] lead);
    return !have_lead || (cand > lead);
  endfunction

  // Limit clamp: zero means one, anything above capacity is capacity.
  function automatic int unsigned clamp_limit(input int unsigned req,
                                              input int unsigned cap);
    if (req == 0) return 1;
    if (req > cap) return cap;
    return req;
  endfunction

  // Energy test: fails when below threshold, unless fixed-count mode is on.
  function automatic logic energy_fails(input logic fixed_mode,
                                        input logic [31:0] energy,
                                        input logic [31:0] thresh);
    return !fixed_mode && (energy < thresh);
  endfunction

endpackage

// File: rtl/sps_keepmax.sv
module sps_keepmax
  import sps_pkg::*;
#(
  parameter int MAG_W = 18,
  parameter int IDX_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             beat_vld,
  input  logic             beat_skip,
  input  logic [IDX_W-1:0] beat_idx,
  input  logic [MAG_W-1:0] beat_mag,
  output logic [IDX_W-1:0] pick_idx
);

  logic [MAG_W-1:0] lead_mag;
  logic [IDX_W-1:0] lead_idx;
  logic             lead_have;
  logic             take;

  assign take     = beat_vld && !beat_skip &&
                    beats_lead(lead_have, 32'(beat_mag), 32'(lead_mag));
  assign pick_idx = take ? beat_idx : lead_idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lead_have <= 1'b0;
      lead_mag  <= '0;
      lead_idx  <= '0;
    end else if (clear) begin
      lead_have <= 1'b0;
      lead_mag  <= '0;
      lead_idx  <= '0;
    end else if (take) begin
      lead_have <= 1'b1;
      lead_mag  <= beat_mag;
      lead_idx  <= beat_idx;
    end
  end

  // R3: within a pass the held maximum never shrinks and is never lost
  a_r3_lead_monotonic: assert property (@(posedge clk) disable iff (!rst_n)
    (lead_have && !clear) |=> (lead_have && lead_mag >= $past(lead_mag)));

  // R4: an excluded column never takes the lead
  a_r4_skip_no_take: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_vld && beat_skip && !clear) |=> $stable(lead_idx));

endmodule

// File: rtl/sps_support.sv
module sps_support #(
  parameter int NCOL  = 101,
  parameter int IDX_W = 7,
  parameter int DEPTH = 8,
  parameter int CNT_W = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   clear,
  input  logic                   push,
  input  logic [IDX_W-1:0]       push_idx,
  input  logic                   pop,
  output logic [DEPTH*IDX_W-1:0] list,
  output logic [CNT_W-1:0]       count,
  output logic [NCOL-1:0]        mask
);

  logic [IDX_W-1:0] slot [DEPTH];
  logic [IDX_W-1:0] top_idx;

  always_comb begin
    top_idx = '0;
    for (int i = 0; i < DEPTH; i++)
      if (count == CNT_W'(i + 1)) top_idx = slot[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       count <= '0;
    else if (clear)   count <= '0;
    else if (push)    count <= count + 1'b1;
    else if (pop)     count <= count - 1'b1;
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                             slot[i] <= '0;
      else if (clear)                         slot[i] <= '0;
      else if (push && count == CNT_W'(i))    slot[i] <= push_idx;
      else if (pop && count == CNT_W'(i + 1)) slot[i] <= '0;
    end
    assign list[i*IDX_W +: IDX_W] = slot[i];
  end

  for (genvar c = 0; c < NCOL; c++) begin : g_mask
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                 mask[c] <= 1'b0;
      else if (clear)                             mask[c] <= 1'b0;
      else if (push && push_idx == IDX_W'(c))     mask[c] <= 1'b1;
      else if (pop && top_idx == IDX_W'(c))       mask[c] <= 1'b0;
    end
  end

  // R4: a pushed index was never already in the support
  a_r4_push_fresh: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !clear) |-> !mask[push_idx]);

  // R12: never push past capacity, never pop an empty list
  a_r12_bounds: assert property (@(posedge clk) disable iff (!rst_n)
    !((push && count == CNT_W'(DEPTH)) || (pop && count == '0)));

endmodule

// File: rtl/sparse_pick_ctrl.sv
module sparse_pick_ctrl
  import sps_pkg::*;
#(
  parameter int NCOL        = 101,
  parameter int MAG_W       = 18,
  parameter int EN_W        = 24,
  parameter int MAX_SUPPORT = 8,
  localparam int IDX_W      = $clog2(NCOL),
  localparam int CNT_W      = $clog2(MAX_SUPPORT + 1)
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         start,
  input  logic [CNT_W-1:0]             cfg_limit,
  input  logic [EN_W-1:0]              cfg_thresh,
  input  logic                         cfg_fixed,
  input  logic                         corr_valid,
  input  logic [MAG_W-1:0]             corr_mag,
  input  logic                         energy_valid,
  input  logic [EN_W-1:0]              energy_val,
  output logic [MAX_SUPPORT*IDX_W-1:0] sup_list,
  output logic [CNT_W-1:0]             sup_count,
  output logic                         done,
  output logic                         stop_by_energy
);

  sps_state_e       state;
  logic [IDX_W-1:0] col;
  logic [CNT_W-1:0] limit_q;
  logic [EN_W-1:0]  thresh_q;
  logic             fixed_q;
  logic [NCOL-1:0]  mask;
  logic [IDX_W-1:0] pick_idx;

  // Named internal events
  logic beat, last_col, pass_end, e_beat, e_low, stop_energy_ev, stop_size_ev;

  assign beat           = (state == ST_MATCH) && corr_valid;
  assign last_col       = (col == IDX_W'(NCOL - 1));
  assign pass_end       = beat && last_col;
  assign e_beat         = (state == ST_WAIT_E) && energy_valid;
  assign e_low          = energy_fails(fixed_q, 32'(energy_val), 32'(thresh_q));
  assign stop_energy_ev = e_beat && e_low;
  assign stop_size_ev   = e_beat && !e_low && (sup_count == limit_q);

  sps_keepmax #(.MAG_W(MAG_W), .IDX_W(IDX_W)) u_max (
    .clk(clk), .rst_n(rst_n),
    .clear(start || pass_end),
    .beat_vld(beat), .beat_skip(mask[col]),
    .beat_idx(col), .beat_mag(corr_mag),
    .pick_idx(pick_idx)
  );

  sps_support #(.NCOL(NCOL), .IDX_W(IDX_W), .DEPTH(MAX_SUPPORT), .CNT_W(CNT_W)) u_sup (
    .clk(clk), .rst_n(rst_n),
    .clear(start),
    .push(pass_end && !start), .push_idx(pick_idx),
    .pop(stop_energy_ev && !start),
    .list(sup_list), .count(sup_count), .mask(mask)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state          <= ST_IDLE;
      col            <= '0;
      limit_q        <= CNT_W'(1);
      thresh_q       <= '0;
      fixed_q        <= 1'b0;
      done           <= 1'b0;
      stop_by_energy <= 1'b0;
    end else if (start) begin
      state          <= ST_MATCH;
      col            <= '0;
      limit_q        <= CNT_W'(clamp_limit(32'(cfg_limit), MAX_SUPPORT));
      thresh_q       <= cfg_thresh;
      fixed_q        <= cfg_fixed;
      done           <= 1'b0;
      stop_by_energy <= 1'b0;
    end else begin
      case (state)
        ST_MATCH: if (beat) begin
          col <= last_col ? '0 : col + 1'b1;
          if (last_col) state <= ST_WAIT_E;
        end
        ST_WAIT_E: if (e_beat) begin
          if (stop_energy_ev) begin
            state          <= ST_DONE;
            done           <= 1'b1;
            stop_by_energy <= 1'b1;
          end else if (stop_size_ev) begin
            state <= ST_DONE;
            done  <= 1'b1;
          end else begin
            state <= ST_MATCH;
          end
        end
        default: ;
      endcase
    end
  end

  // R2: the end of a pass appends exactly one index
  a_r2_append: assert property (@(posedge clk) disable iff (!rst_n)
    (pass_end && !start) |=> (sup_count == $past(sup_count) + 1'b1));

  // R6: an energy stop removes the last index and reports energy as the reason
  a_r6_energy_stop: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_energy_ev && !start) |=> (done && stop_by_energy &&
                                    sup_count == $past(sup_count) - 1'b1));

  // R7: the count never exceeds the captured limit
  a_r7_count_cap: assert property (@(posedge clk) disable iff (!rst_n)
    sup_count <= limit_q);

  // R11: a finished run holds its result until the next start
  a_r11_done_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> (done && $stable(sup_count) && $stable(sup_list)));

endmodule

// File: tb/sparse_pick_ctrl_test.sv
module sparse_pick_ctrl_test;

  localparam int NCOL = 101;
  localparam int IDX_W = 7;
  localparam int DEP = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [3:0] cfg_limit = '0;
  logic [23:0] cfg_thresh = '0;
  logic cfg_fixed = 1'b0;
  logic corr_valid = 1'b0;
  logic [17:0] corr_mag = '0;
  logic energy_valid = 1'b0;
  logic [23:0] energy_val = '0;
  logic [DEP*IDX_W-1:0] sup_list;
  logic [3:0] sup_count;
  logic done, stop_by_energy;

  sparse_pick_ctrl uut (
    .clk(clk), .rst_n(rst_n), .start(start),
    .cfg_limit(cfg_limit), .cfg_thresh(cfg_thresh), .cfg_fixed(cfg_fixed),
    .corr_valid(corr_valid), .corr_mag(corr_mag),
    .energy_valid(energy_valid), .energy_val(energy_val),
    .sup_list(sup_list), .sup_count(sup_count),
    .done(done), .stop_by_energy(stop_by_energy)
  );

  always #10 clk = ~clk;

  int n_tests = 0;
  int n_fail = 0;

  // Reference model
  int mg[NCOL];
  bit mm[NCOL];
  int ml[DEP];
  int mc, m_lim, m_th;
  bit m_fix, m_done, m_se;

  task automatic check(string req, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic check_slots(string req);
    for (int i = 0; i < DEP; i++)
      check(req, int'(sup_list[i*IDX_W +: IDX_W]), (i < mc) ? ml[i] : 0);
  endtask

  task automatic fill(int it);
    for (int c = 0; c < NCOL; c++) mg[c] = (c * 37 + it * 53 + 11) % 1000;
  endtask

  function automatic int ref_pick();
    int b = -1;
    int bm = -1;
    for (int c = 0; c < NCOL; c++)
      if (!mm[c] && mg[c] > bm) begin
        bm = mg[c];
        b = c;
      end
    return b;
  endfunction

  task automatic begin_run(int lim, int th, bit fx);
    @(negedge clk);
    start = 1'b1; cfg_limit = 4'(lim); cfg_thresh = 24'(th); cfg_fixed = fx;
    @(negedge clk);
    start = 1'b0;
    m_lim = (lim == 0) ? 1 : (lim > DEP ? DEP : lim);
    m_th = th; m_fix = fx; m_done = 0; m_se = 0; mc = 0;
    for (int c = 0; c < NCOL; c++) mm[c] = 0;
    for (int i = 0; i < DEP; i++) ml[i] = 0;
    check("R1 count cleared", int'(sup_count), 0);
    check("R1 done cleared", int'(done), 0);
  endtask

  // One matching pass; optional stray energy beat in the middle (R11)
  task automatic run_pass(bit stray_energy);
    int p;
    p = ref_pick();
    for (int c = 0; c < NCOL; c++) begin
      corr_valid = 1'b1;
      corr_mag = 18'(mg[c]);
      energy_valid = stray_energy && (c == 50);
      energy_val = '0;
      @(negedge clk);
    end
    corr_valid = 1'b0;
    energy_valid = 1'b0;
    ml[mc] = p; mm[p] = 1; mc++;
    check("R2 count after pass", int'(sup_count), mc);
    check("R3 R4 chosen index", int'(sup_list[(mc-1)*IDX_W +: IDX_W]), p);
    check("R11 not done after pass", int'(done), 0);
  endtask

  task automatic send_energy(int e);
    bit low;
    energy_valid = 1'b1;
    energy_val = 24'(e);
    @(negedge clk);
    energy_valid = 1'b0;
    low = !m_fix && (e < m_th);
    if (low) begin
      mc--; mm[ml[mc]] = 0; ml[mc] = 0; m_done = 1; m_se = 1;
    end else if (mc == m_lim) begin
      m_done = 1;
    end
    check("R5 R6 R7 done", int'(done), int'(m_done));
    check("R6 R7 stop reason", int'(stop_by_energy), int'(m_se));
    check("R6 R9 count", int'(sup_count), mc);
    check_slots("R12 slots");
  endtask

  task automatic t_reset();
    check("R1 reset count", int'(sup_count), 0);
    check("R1 reset done", int'(done), 0);
    check("R1 reset reason", int'(stop_by_energy), 0);
    check("R1 reset list", int'(sup_list != '0), 0);
  endtask

  task automatic t_energy_stop();
    begin_run(5, 100, 0);
    fill(0); run_pass(0); send_energy(500);
    fill(1); run_pass(0); send_energy(400);
    fill(2); run_pass(0); send_energy(50);
    check("R6 final count", int'(sup_count), 2);
    check("R6 reason energy", int'(stop_by_energy), 1);
  endtask

  task automatic t_size_stop();
    begin_run(3, 100, 0);
    fill(3); run_pass(0); send_energy(1000);
    fill(4); run_pass(1); send_energy(1000);
    fill(5); run_pass(0); send_energy(1000);
    check("R7 final count", int'(sup_count), 3);
    check("R7 reason size", int'(stop_by_energy), 0);
    // R11: inputs after done are ignored
    for (int c = 0; c < 5; c++) begin
      corr_valid = 1'b1; corr_mag = 18'h3FFFF;
      energy_valid = 1'b1; energy_val = '0;
      @(negedge clk);
    end
    corr_valid = 1'b0; energy_valid = 1'b0;
    check("R11 count held", int'(sup_count), 3);
    check("R11 done held", int'(done), 1);
    check_slots("R11 list held");
  endtask

  task automatic t_fixed();
    begin_run(4, 1000, 1);
    for (int it = 0; it < 4; it++) begin
      fill(6 + it); run_pass(0); send_energy(0);
    end
    check("R8 fixed count", int'(sup_count), 4);
    check("R8 reason size", int'(stop_by_energy), 0);
  endtask

  task automatic t_exclusion();
    begin_run(3, 10, 0);
    fill(7); mg[40] = 200000; run_pass(0);
    check("R4 first pick", int'(sup_list[0 +: IDX_W]), 40);
    send_energy(100);
    run_pass(0);
    check("R4 excluded column not rechosen", int'(sup_list[IDX_W +: IDX_W] == 40), 0);
    send_energy(100);
  endtask

  task automatic t_tie();
    begin_run(2, 10, 0);
    fill(8); mg[10] = 150000; mg[60] = 150000; run_pass(0);
    check("R3 tie lower index", int'(sup_list[0 +: IDX_W]), 10);
    send_energy(100);
    run_pass(0);
    check("R3 R4 tie second pick", int'(sup_list[IDX_W +: IDX_W]), 60);
    send_energy(100);
  endtask

  task automatic t_coincide();
    begin_run(2, 100, 0);
    fill(9); run_pass(0); send_energy(500);
    fill(10); run_pass(0); send_energy(20);
    check("R9 count after coincidence", int'(sup_count), 1);
    check("R9 reason energy", int'(stop_by_energy), 1);
  endtask

  task automatic t_clamp();
    begin_run(0, 10, 0);
    fill(11); run_pass(0); send_energy(100);
    check("R10 zero limit acts as one", int'(done), 1);
    begin_run(15, 10, 1);
    for (int it = 0; it < DEP; it++) begin
      fill(12 + it); run_pass(0); send_energy(0);
    end
    check("R10 large limit clamped", int'(sup_count), DEP);
    check("R10 done at capacity", int'(done), 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_energy_stop();
    t_size_stop();
    t_fixed();
    t_exclusion();
    t_tie();
    t_coincide();
    t_clamp();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(20ns * 150000);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule